// File: doc/BRIEF.md
# Power Unit Fault Status Collector

This block gathers the fault and event conditions of a bus-managed power unit into one status word that a host can read. Five raw conditions feed it: fan failure, over-temperature warning, over-temperature shutdown, over-voltage shutdown and internal fault. Their bits show the present condition and are not frozen at the first fault. Two communication error pulses, a checksum error and a data error, set bits that stay set until the host sends an explicit clear-all command. A pulse from the auto-restart logic sets a restart flag. That flag keeps a momentary protective shutdown visible after the fault itself has gone.

The host reads through a protocol engine, which lies outside this block. When the engine finishes a successful read of the word it pulses `rd_done_i`. That pulse clears the restart flag and the changed flag, but it leaves the communication error bits alone. Any change in the word raises a changed flag and drives an active-low alert. A separate active-low fault line summarises the five conditions that call for the unit to be replaced. Every output is registered.

Top module: `pwr_fault_status`

## Requirements
- R1: After synchronous reset, `status_o` is all zeros, `changed_o` and `restart_o` are 0, and `alert_n_o` and `fault_n_o` are 1.
- R2: Status bits [LIVE_W-1:0] hold the value `cond_i` had at the previous clock edge. The exception is the cycle after a clear-all, covered by R10. Bit 0 is fan failure, bit 1 over-temperature warning, bit 2 over-temperature shutdown, bit 3 over-voltage shutdown and bit 4 internal fault.
- R3: A condition that is still present at the edge where `rd_done_i` is high keeps its bit set.
- R4: Status bits [LIVE_W+2:LIVE_W+1] are set by a `comm_err_i` pulse and stay set through any number of reads. Only `clr_all_i` clears them. `comm_err_i[0]` is the checksum error and `comm_err_i[1]` is the data error.
- R5: A `comm_err_i` pulse at the same edge as `clr_all_i` leaves its bit set.
- R6: Status bit LIVE_W and `restart_o` are set by a `restart_evt_i` pulse. They stay set until a read or a clear-all. If a restart pulse arrives at the same edge as a read, the flag stays set.
- R7: `changed_o` is set at an edge where the word would change if no read or clear acted. A read with no such change pending clears it. A clear-all always clears it.
- R8: `alert_n_o` is low exactly when `changed_o` is high.
- R9: `fault_n_o` is low one cycle after any bit of `cond_i` is high. Communication errors and restart events have no effect on it.
- R10: `clr_all_i` clears every status bit, `restart_o` and `changed_o` at the next edge. Conditions still present set their bits again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | LIVE_W | Raw fault conditions, level |
| restart_evt_i | input | 1 | Auto-restart event pulse |
| comm_err_i | input | COMM_W | Communication error pulses (bit 0 checksum, bit 1 data) |
| rd_done_i | input | 1 | Successful host read of the status word |
| clr_all_i | input | 1 | Clear-all-faults command strobe |
| status_o | output | LIVE_W+1+COMM_W | Status word: conditions, restart, communication errors |
| changed_o | output | 1 | Word changed since the last read |
| alert_n_o | output | 1 | Active-low alert |
| fault_n_o | output | 1 | Active-low summary fault line |
| restart_o | output | 1 | Restart-occurred flag |

## Verification
The bench builds the block with its defaults, LIVE_W = 5 and COMM_W = 2, so the status word is 8 bits wide. This width is small enough that random condition toggles, error pulses, reads and clears reach every bit of the word and every collision of a read or a clear with a new event. Directed cases pin down three collisions: a read against a condition that is still present, an error pulse against a clear-all, and a restart pulse against a read. They also cover the one-cycle gap after a clear-all, before live conditions come back.

// File: rtl/pwr_fault_pkg.sv
package pwr_fault_pkg;
  function automatic int status_width(input int live_w, input int comm_w);
    return live_w + 1 + comm_w;
  endfunction
endpackage

// File: rtl/fsr_live_bits.sv
module fsr_live_bits #(
  parameter int LIVE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LIVE_W-1:0] cond_i,
  input  logic              restart_evt_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [LIVE_W-1:0] live_q,
  output logic              restart_q,
  output logic              fault_n_q,
  output logic [LIVE_W-1:0] live_raw,
  output logic              restart_raw
);
  // values the word would take if neither read nor clear acted
  assign live_raw    = cond_i;
  assign restart_raw = restart_q | restart_evt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= '0;
      restart_q <= 1'b0;
      fault_n_q <= 1'b1;
    end else begin
      live_q    <= clr_i ? '0 : cond_i;
      if (restart_evt_i)        restart_q <= 1'b1;
      else if (clr_i || rd_i)   restart_q <= 1'b0;
      fault_n_q <= ~(|cond_i);
    end
  end

  a_r2_live_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_i)) |-> (live_q == $past(cond_i)));
  a_r10_clear_live: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_i)) |-> (live_q == '0));
  a_r6_restart_set: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restart_evt_i)) |-> restart_q);
  a_r9_fault_line: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|cond_i)) |-> !fault_n_q);
endmodule

// File: rtl/fsr_sticky_bits.sv
module fsr_sticky_bits #(
  parameter int COMM_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COMM_W-1:0] err_i,
  input  logic              clr_i,
  output logic [COMM_W-1:0] err_q,
  output logic [COMM_W-1:0] err_raw
);
  for (genvar g = 0; g < COMM_W; g++) begin : g_err
    assign err_raw[g] = err_q[g] | err_i[g];
    always_ff @(posedge clk) begin
      if (rst)            err_q[g] <= 1'b0;
      else if (err_i[g])  err_q[g] <= 1'b1;
      else if (clr_i)     err_q[g] <= 1'b0;
    end
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(err_q[g]) && !$past(clr_i)) |-> err_q[g]);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(err_i[g])) |-> err_q[g]);
  end
endmodule

// File: rtl/fsr_change_tracker.sv
module fsr_change_tracker #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_q,
  input  logic [WORD_W-1:0] word_raw,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic              changed_q,
  output logic              alert_n_q
);
  logic evt;
  logic chg_next;
  assign evt = (word_raw != word_q);

  always_comb begin
    if (clr_i)      chg_next = 1'b0;
    else if (evt)   chg_next = 1'b1;
    else if (rd_i)  chg_next = 1'b0;
    else            chg_next = changed_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      changed_q <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      changed_q <= chg_next;
      alert_n_q <= ~chg_next;
    end
  end

  a_r8_alert_tracks: assert property (@(posedge clk) disable iff (rst)
    alert_n_q == !changed_q);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_i) && !$past(evt)) |-> !changed_q);
  a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(evt) && !$past(clr_i)) |-> changed_q);
endmodule

// File: rtl/pwr_fault_status.sv
module pwr_fault_status
  import pwr_fault_pkg::*;
#(
  parameter int LIVE_W = 5,
  parameter int COMM_W = 2,
  localparam int WORD_W = status_width(LIVE_W, COMM_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LIVE_W-1:0] cond_i,
  input  logic              restart_evt_i,
  input  logic [COMM_W-1:0] comm_err_i,
  input  logic              rd_done_i,
  input  logic              clr_all_i,
  output logic [WORD_W-1:0] status_o,
  output logic              changed_o,
  output logic              alert_n_o,
  output logic              fault_n_o,
  output logic              restart_o
);
  logic [LIVE_W-1:0] live_q, live_raw;
  logic              rs_q, rs_raw;
  logic [COMM_W-1:0] err_q, err_raw;
  logic [WORD_W-1:0] word_raw;

  fsr_live_bits #(.LIVE_W(LIVE_W)) u_live (
    .clk(clk), .rst(rst), .cond_i(cond_i), .restart_evt_i(restart_evt_i),
    .rd_i(rd_done_i), .clr_i(clr_all_i), .live_q(live_q), .restart_q(rs_q),
    .fault_n_q(fault_n_o), .live_raw(live_raw), .restart_raw(rs_raw));

  fsr_sticky_bits #(.COMM_W(COMM_W)) u_sticky (
    .clk(clk), .rst(rst), .err_i(comm_err_i), .clr_i(clr_all_i),
    .err_q(err_q), .err_raw(err_raw));

  assign status_o = {err_q, rs_q, live_q};
  assign word_raw = {err_raw, rs_raw, live_raw};
  assign restart_o = rs_q;

  fsr_change_tracker #(.WORD_W(WORD_W)) u_chg (
    .clk(clk), .rst(rst), .word_q(status_o), .word_raw(word_raw),
    .rd_i(rd_done_i), .clr_i(clr_all_i), .changed_q(changed_o),
    .alert_n_q(alert_n_o));

  a_r10_clear_all: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_all_i) && !$past(restart_evt_i) && !$past(|comm_err_i))
      |-> (status_o == '0 && !changed_o));
endmodule

// File: tb/test_pwr_fault_status.sv
module test_pwr_fault_status;
  localparam int LW = 5;
  localparam int CW = 2;
  localparam int WW = LW + 1 + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LW-1:0] cond = '0;
  logic rs_evt = 1'b0;
  logic [CW-1:0] err = '0;
  logic rd = 1'b0;
  logic clr = 1'b0;
  logic [WW-1:0] status;
  logic changed, alert_n, fault_n, restart;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected state
  logic [LW-1:0] m_live = '0;
  logic m_rs = 1'b0;
  logic [CW-1:0] m_err = '0;
  logic m_chg = 1'b0;
  logic m_fault_n = 1'b1;

  always #4 clk = ~clk;

  pwr_fault_status #(.LIVE_W(LW), .COMM_W(CW)) i_pwr_fault_status (
    .clk(clk), .rst(rst), .cond_i(cond), .restart_evt_i(rs_evt),
    .comm_err_i(err), .rd_done_i(rd), .clr_all_i(clr), .status_o(status),
    .changed_o(changed), .alert_n_o(alert_n), .fault_n_o(fault_n),
    .restart_o(restart));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] model_word();
    return {m_err, m_rs, m_live};
  endfunction

  // advance the model by one edge with the inputs now applied
  task automatic model_step();
    logic [WW-1:0] raw;
    logic evt;
    raw = {m_err | err, m_rs | rs_evt, cond};
    evt = (raw != model_word());
    if (clr) m_chg = 1'b0;
    else if (evt) m_chg = 1'b1;
    else if (rd) m_chg = 1'b0;
    m_live = clr ? '0 : cond;
    if (rs_evt) m_rs = 1'b1;
    else if (clr || rd) m_rs = 1'b0;
    m_err = err | (clr ? '0 : m_err);
    m_fault_n = ~(|cond);
  endtask

  task automatic check_all();
    chk("R2 live bits", 32'(status[LW-1:0]), 32'(m_live));
    chk("R6 restart bit", 32'(status[LW]), 32'(m_rs));
    chk("R6 restart flag", 32'(restart), 32'(m_rs));
    chk("R4 comm bits", 32'(status[WW-1:LW+1]), 32'(m_err));
    chk("R7 changed", 32'(changed), 32'(m_chg));
    chk("R8 alert", 32'(alert_n), 32'(!m_chg));
    chk("R9 fault line", 32'(fault_n), 32'(m_fault_n));
  endtask

  task automatic step(input logic [LW-1:0] c, input logic r, input logic [CW-1:0] e,
                      input logic rdv, input logic cl);
    cond = c; rs_evt = r; err = e; rd = rdv; clr = cl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 status", 32'(status), 0);
    chk("R1 changed", 32'(changed), 0);
    chk("R1 restart", 32'(restart), 0);
    chk("R1 alert_n", 32'(alert_n), 1);
    chk("R1 fault_n", 32'(fault_n), 1);

    // R2/R9: momentary over-voltage shutdown then recovery
    step(5'b01000, 0, 0, 0, 0);
    chk("R9 fault low", 32'(fault_n), 0);
    step(5'b00000, 1, 0, 0, 0);
    chk("R2 bit erased", 32'(status[3]), 0);
    chk("R6 restart held", 32'(restart), 1);
    // R3: read while fan failure present
    step(5'b00001, 0, 0, 0, 0);
    step(5'b00001, 0, 0, 1, 0);
    chk("R3 condition wins", 32'(status[0]), 1);
    chk("R6 read clears restart", 32'(restart), 0);
    chk("R7 read clears changed", 32'(changed), 0);
    // R9: comm error and restart leave fault line alone
    step(5'b00000, 1, 2'b11, 0, 0);
    chk("R9 no fault from comm/restart", 32'(fault_n), 1);
    // R4: sticky through reads
    step(5'b00000, 0, 0, 1, 0);
    step(5'b00000, 0, 0, 1, 0);
    chk("R4 comm sticky", 32'(status[WW-1:LW+1]), 2'b11);
    // R6: restart with read
    step(5'b00000, 1, 0, 1, 0);
    chk("R6 restart wins read", 32'(restart), 1);
    // R5: error with clear-all
    step(5'b00010, 0, 2'b10, 0, 1);
    chk("R5 set wins clear", 32'(status[WW-1:LW+1]), 2'b10);
    chk("R10 live cleared", 32'(status[LW-1:0]), 0);
    chk("R10 restart cleared", 32'(restart), 0);
    step(5'b00010, 0, 0, 0, 1);
    chk("R10 all clear", 32'(status), 0);
    chk("R10 changed cleared", 32'(changed), 0);
    step(5'b00010, 0, 0, 0, 0);
    chk("R10 reload", 32'(status[1]), 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [LW-1:0] c;
      c = cond;
      for (int b = 0; b < LW; b++) if ($urandom_range(7) == 0) c[b] = ~c[b];
      step(c, $urandom_range(15) == 0,
           CW'({$urandom_range(15) == 0, $urandom_range(15) == 0}),
           $urandom_range(5) == 0, $urandom_range(19) == 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule